// File: doc/BRIEF.md
# ADC Input Scan Sequencer

This block decides which analog input the converter samples next and stores each returned result in a small indexed result buffer. A bitmask selects a set of primary-mux inputs to walk through in ascending order. One fixed secondary-mux input can be interleaved with them, so that every other conversion uses it. The converter reports each finished conversion with a one-cycle done strobe and a result word. The sequencer writes that word into the next buffer slot, moves to the next channel, and raises a one-cycle interrupt once a programmed number of results has been collected.

The channel presented on `ch_o` is the one the next conversion must use, and `is_sec_o` marks a secondary-mux conversion. Software or a bus bridge elsewhere reads results through the combinational read port. When scan and alternate modes are both on, every set bit of the mask is visited, including the highest one, before the walk wraps back to the lowest set input.

Top module: `adc_scan_seq`

## Requirements
- R1: With scan enabled and a non-zero mask, each primary conversion uses an input whose mask bit is set, and successive primary conversions step through the set bits in ascending input number, starting from the lowest set bit after reset.
- R2: After the highest set mask bit has been converted, the next primary conversion uses the lowest set bit. The highest set bit, including input NUM_CH-1, is never skipped, with or without alternate mode.
- R3: With alternate mode enabled, conversions alternate primary, secondary, primary, and so on, starting with a primary conversion after reset. A secondary conversion drives `ch_o` = `cfg_sec_ch` and `is_sec_o` = 1.
- R4: With scan inputs {3,4,5}, secondary input 6 and both modes on, buffer slots 0..7 receive results from inputs 3,6,4,6,5,6,3,6 in that order.
- R5: With alternate mode disabled, every conversion is primary (`is_sec_o` = 0), and `cfg_sec_ch` has no effect on `ch_o`.
- R6: With scan disabled, or with scan enabled and an all-zero mask, every primary conversion uses `cfg_pri_ch`.
- R7: Each done strobe writes `result_i` into buffer slot `wr_ptr`, counting up from slot 0. `rd_data_o` returns the content of slot `rd_idx_i` in the same cycle.
- R8: `irq_o` is high for exactly the one cycle after the done strobe of conversion number `cfg_irq_cnt`+1 in the current group. The write pointer then returns to slot 0 and the count restarts.
- R9: After reset, `irq_o` is 0, the next conversion is primary, the write pointer is at slot 0 and every buffer slot reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_scan_en | input | 1 | Enable mask-driven scanning of primary inputs |
| cfg_alt_en | input | 1 | Enable alternation with the secondary input |
| cfg_scan_mask | input | NUM_CH | Set of primary inputs to scan; bit i selects input i |
| cfg_pri_ch | input | CH_W | Fixed primary input, used when scanning is inactive |
| cfg_sec_ch | input | CH_W | Fixed secondary input |
| cfg_irq_cnt | input | PTR_W | Conversions per interrupt, minus one |
| done_i | input | 1 | One-cycle strobe: conversion on `ch_o` has finished |
| result_i | input | RES_W | Result word that comes with `done_i` |
| rd_idx_i | input | PTR_W | Buffer read index |
| ch_o | output | CH_W | Input to use for the next conversion |
| is_sec_o | output | 1 | Next conversion goes through the secondary mux |
| rd_data_o | output | RES_W | Content of buffer slot `rd_idx_i` |
| irq_o | output | 1 | One-cycle interrupt pulse when a result group is complete |

## Verification
The bench goes after the last set bit of the mask under alternation. A design that drops it converts one input less per pass, and the result order 3,6,4,6,5,6,3,6 and a mask holding input 15 both expose this. It sweeps single-bit, sparse, dense, full and empty masks. A wrong wrap or a wrong empty-mask fallback shows up as a wrong `ch_o` on the first conversion after the top bit, or as a stalled channel. Interrupt groups of 4, 8 and 16 conversions check that a design which fires one result early or late, or which fails to send the write pointer back to slot 0, leaves the buffer contents out of step with the model. The secondary channel setting is changed on every conversion while alternation is off, which catches any leak of the secondary select onto `ch_o`.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   // Which mux the next conversion goes through
   typedef enum logic {
      PH_PRI = 1'b0,
      PH_SEC = 1'b1
   } phase_e;

endpackage

// File: rtl/adc_scan_pick.sv
// Finds the first set mask bit at or above a start position, wrapping
// around the top of the input range.
module adc_scan_pick #(
   parameter int NUM_CH = 16,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] mask,
   input  logic [CH_W-1:0]   start,
   output logic [CH_W-1:0]   sel
);

   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("adc_scan_pick: NUM_CH must be a power of two, at least 2");
   end

   logic [CH_W-1:0] idx;

   // Search from farthest to nearest so that the nearest set bit wins
   always_comb begin
      sel = start;
      idx = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         idx = start + CH_W'(i);
         if (mask[idx]) begin
            sel = idx;
         end
      end
   end

endmodule

// File: rtl/adc_scan_buf.sv
// Small result store: one write port, one combinational read port.
module adc_scan_buf #(
   parameter int DEPTH = 16,
   parameter int DW    = 12,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [PTR_W-1:0] waddr,
   input  logic [DW-1:0]    wdata,
   input  logic [PTR_W-1:0] raddr,
   output logic [DW-1:0]    rdata
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("adc_scan_buf: DEPTH must be a power of two, at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("adc_scan_buf: DW must be positive");
   end

   logic [DW-1:0] slot_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[g] <= '0;
         end else if (we && waddr == PTR_W'(g)) begin
            slot_q[g] <= wdata;
         end
      end
   end

   assign rdata = slot_q[raddr];

endmodule

// File: rtl/adc_scan_seq.sv
// Scan sequencer: walks the primary scan set, interleaves the secondary
// input, stores results and counts them toward an interrupt.
module adc_scan_seq
   import adc_scan_pkg::*;
#(
   parameter int NUM_CH    = 16,
   parameter int RES_W     = 12,
   parameter int BUF_DEPTH = 16,
   localparam int CH_W  = $clog2(NUM_CH),
   localparam int PTR_W = $clog2(BUF_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_scan_en,
   input  logic              cfg_alt_en,
   input  logic [NUM_CH-1:0] cfg_scan_mask,
   input  logic [CH_W-1:0]   cfg_pri_ch,
   input  logic [CH_W-1:0]   cfg_sec_ch,
   input  logic [PTR_W-1:0]  cfg_irq_cnt,
   input  logic              done_i,
   input  logic [RES_W-1:0]  result_i,
   input  logic [PTR_W-1:0]  rd_idx_i,
   output logic [CH_W-1:0]   ch_o,
   output logic              is_sec_o,
   output logic [RES_W-1:0]  rd_data_o,
   output logic              irq_o
);

   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("adc_scan_seq: NUM_CH must be a power of two, at least 2");
   end
   if (BUF_DEPTH < 2 || (BUF_DEPTH & (BUF_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("adc_scan_seq: BUF_DEPTH must be a power of two, at least 2");
   end

   phase_e           phase_q;
   logic [CH_W-1:0]  scan_ptr_q;
   logic [PTR_W-1:0] wr_ptr_q;
   logic             irq_q;

   logic             scan_act;
   logic             sec_now;
   logic             grp_last;
   logic [CH_W-1:0]  pick_ch;
   logic [CH_W-1:0]  pri_ch;

   // Scanning only takes over when at least one input is selected
   assign scan_act = cfg_scan_en && (|cfg_scan_mask);
   assign sec_now  = cfg_alt_en && (phase_q == PH_SEC);
   assign grp_last = (wr_ptr_q == cfg_irq_cnt);

   adc_scan_pick #(
      .NUM_CH (NUM_CH)
   ) u_pick (
      .mask  (cfg_scan_mask),
      .start (scan_ptr_q),
      .sel   (pick_ch)
   );

   assign pri_ch   = scan_act ? pick_ch : cfg_pri_ch;
   assign ch_o     = sec_now ? cfg_sec_ch : pri_ch;
   assign is_sec_o = sec_now;
   assign irq_o    = irq_q;

   // Sequence state: phase, scan position, buffer pointer, interrupt
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_PRI;
         scan_ptr_q <= '0;
         wr_ptr_q   <= '0;
         irq_q      <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (done_i) begin
            if (sec_now) begin
               phase_q <= PH_PRI;
            end else begin
               phase_q <= cfg_alt_en ? PH_SEC : PH_PRI;
               // Resume the search just above the input converted now
               if (scan_act) begin
                  scan_ptr_q <= pick_ch + CH_W'(1);
               end
            end
            wr_ptr_q <= grp_last ? '0 : wr_ptr_q + PTR_W'(1);
            irq_q    <= grp_last;
         end
      end
   end

   adc_scan_buf #(
      .DEPTH (BUF_DEPTH),
      .DW    (RES_W)
   ) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (done_i),
      .waddr (wr_ptr_q),
      .wdata (result_i),
      .raddr (rd_idx_i),
      .rdata (rd_data_o)
   );

   // R1: a scanned primary conversion always uses a selected input
   a_r1_scan_member: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_act && !is_sec_o) |-> cfg_scan_mask[ch_o]);

   // R3: a primary conversion under alternation is followed by a secondary one
   a_r3_pri_then_sec: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && cfg_alt_en && !is_sec_o) |=> (is_sec_o || !cfg_alt_en));

   // R3: a secondary conversion is followed by a primary one
   a_r3_sec_then_pri: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && is_sec_o) |=> !is_sec_o);

   // R6: with scanning off, the primary input is the fixed one
   a_r6_fixed_pri: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_scan_en && !is_sec_o) |-> (ch_o == cfg_pri_ch));

   // R7: the write pointer only moves on a done strobe
   a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_i |=> $stable(wr_ptr_q));

   // R8: the interrupt follows a done strobe and leaves the pointer at slot 0
   a_r8_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($past(done_i) && wr_ptr_q == '0));

endmodule

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_scan_seq;

   localparam int NCH = 16;
   localparam int RW  = 12;
   localparam int DEP = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_scan_en = 1'b0;
   logic           cfg_alt_en = 1'b0;
   logic [NCH-1:0] cfg_scan_mask = '0;
   logic [3:0]     cfg_pri_ch = 4'd9;
   logic [3:0]     cfg_sec_ch = 4'd0;
   logic [3:0]     cfg_irq_cnt = 4'd7;
   logic           done_i = 1'b0;
   logic [RW-1:0]  result_i = '0;
   logic [3:0]     rd_idx_i = '0;
   logic [3:0]     ch_o;
   logic           is_sec_o;
   logic [RW-1:0]  rd_data_o;
   logic           irq_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // Reference model state
   int m_ptr;
   bit m_sec;
   int m_wp;
   int exp_buf [DEP];
   int seq_tag;

   always #2 clk = ~clk;

   adc_scan_seq dut (
      .clk(clk), .rst_n(rst_n), .cfg_scan_en(cfg_scan_en),
      .cfg_alt_en(cfg_alt_en), .cfg_scan_mask(cfg_scan_mask),
      .cfg_pri_ch(cfg_pri_ch), .cfg_sec_ch(cfg_sec_ch),
      .cfg_irq_cnt(cfg_irq_cnt), .done_i(done_i), .result_i(result_i),
      .rd_idx_i(rd_idx_i), .ch_o(ch_o), .is_sec_o(is_sec_o),
      .rd_data_o(rd_data_o), .irq_o(irq_o)
   );

   task automatic chk(int act, int exp, string req);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // First set bit at or above 'from', wrapping; -1 for an empty mask
   function automatic int next_set(logic [NCH-1:0] m, int from);
      for (int i = 0; i < NCH; i++) begin
         if (m[(from + i) % NCH]) return (from + i) % NCH;
      end
      return -1;
   endfunction

   function automatic int exp_ch();
      if (cfg_alt_en && m_sec) return int'(cfg_sec_ch);
      if (cfg_scan_en && cfg_scan_mask != 0) return next_set(cfg_scan_mask, m_ptr);
      return int'(cfg_pri_ch);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      done_i = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_ptr = 0;
      m_sec = 0;
      m_wp = 0;
      for (int i = 0; i < DEP; i++) exp_buf[i] = 0;
   endtask

   // One conversion: check the requested channel, strobe done, check irq
   task automatic convert(string req);
      int ch;
      int data;
      bit last;
      @(negedge clk);
      ch = exp_ch();
      chk(int'(ch_o), ch, req);
      chk(int'(is_sec_o), int'(cfg_alt_en && m_sec), req);
      seq_tag = (seq_tag + 1) % 256;
      data = ch * 256 + seq_tag;
      done_i = 1'b1;
      result_i = RW'(data);
      @(negedge clk);
      done_i = 1'b0;
      last = (m_wp == int'(cfg_irq_cnt));
      chk(int'(irq_o), int'(last), "R8 irq pulse");
      exp_buf[m_wp] = data;
      m_wp = last ? 0 : m_wp + 1;
      if (cfg_alt_en && m_sec) begin
         m_sec = 0;
      end else begin
         m_sec = cfg_alt_en;
         if (cfg_scan_en && cfg_scan_mask != 0) m_ptr = (ch + 1) % NCH;
      end
      @(negedge clk);
      chk(int'(irq_o), 0, "R8 irq one cycle");
   endtask

   task automatic check_buf(string req);
      for (int i = 0; i < DEP; i++) begin
         rd_idx_i = 4'(i);
         #0.1;
         chk(int'(rd_data_o), exp_buf[i], req);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int order [8];
      seq_tag = 0;
      order = '{3, 6, 4, 6, 5, 6, 3, 6};

      // R9: reset state
      do_reset();
      @(negedge clk);
      chk(int'(irq_o), 0, "R9 irq");
      chk(int'(is_sec_o), 0, "R9 phase");
      chk(int'(ch_o), 9, "R9 channel");
      check_buf("R9 buffer cleared");

      // R4 and R8: scan {3,4,5} interleaved with 6, 8 per interrupt
      cfg_scan_en = 1; cfg_alt_en = 1; cfg_scan_mask = 16'h0038;
      cfg_sec_ch = 4'd6; cfg_irq_cnt = 4'd7;
      do_reset();
      for (int k = 0; k < 8; k++) convert("R4 combined order");
      for (int k = 0; k < 8; k++) begin
         rd_idx_i = 4'(k);
         #0.1;
         chk(int'(rd_data_o) / 256, order[k], "R4 slot source");
      end
      for (int k = 0; k < 8; k++) convert("R8 second group");
      check_buf("R7 R8 pointer restart");

      // R1, R2, R5, R6: scan-only sweep, secondary setting ignored
      cfg_alt_en = 0; cfg_irq_cnt = 4'd3;
      for (int v = 0; v < 7; v++) begin
         case (v)
            0: cfg_scan_mask = 16'h0001;
            1: cfg_scan_mask = 16'h8000;
            2: cfg_scan_mask = 16'h8001;
            3: cfg_scan_mask = 16'hA5A5;
            4: cfg_scan_mask = 16'h0FF0;
            5: cfg_scan_mask = 16'hFFFF;
            default: cfg_scan_mask = 16'h0000;
         endcase
         do_reset();
         for (int k = 0; k < 20; k++) begin
            cfg_sec_ch = 4'(k * 5 + v);
            convert("R1 R2 R5 R6 scan only");
         end
         check_buf("R7 scan only buffer");
      end

      // R3: alternation with scanning off
      cfg_scan_en = 0; cfg_alt_en = 1; cfg_pri_ch = 4'd7; cfg_sec_ch = 4'd12;
      cfg_irq_cnt = 4'd15;
      do_reset();
      for (int k = 0; k < 20; k++) convert("R3 alternate fixed");
      check_buf("R7 alternate buffer");

      // R2: last input converted under alternation
      cfg_scan_en = 1; cfg_scan_mask = 16'h8010; cfg_sec_ch = 4'd0;
      cfg_irq_cnt = 4'd11;
      do_reset();
      for (int k = 0; k < 12; k++) convert("R2 top bit with alternate");
      check_buf("R2 top bit buffer");

      // R6: empty mask with scan and alternate on
      cfg_scan_mask = 16'h0000; cfg_pri_ch = 4'd2; cfg_sec_ch = 4'd14;
      cfg_irq_cnt = 4'd5;
      do_reset();
      for (int k = 0; k < 10; k++) convert("R6 empty mask");
      check_buf("R6 empty mask buffer");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule